// File: doc/BRIEF.md
# Reloadable Down-Counter Tone Generator

This block divides a clock by a programmable amount and drives a square wave on a single output. An 8-bit down-counter counts on a count tick. The tick comes either from every clock or from an internal divide-by-64 prescaler. When the counter underflows it reloads itself from a buffer, gives a one-cycle underflow pulse and toggles the tone output. Each period of the output therefore spans 2 × (reload + 1) ticks.

Software writes the reload buffer as two 4-bit halves, each with its own strobe. Any such write halts counting until a mode write sets the run bit again. The same mode write also picks the tick source. On the edge where the run bit goes from clear to set, the counter takes the buffer value. A restart therefore always begins a full period.

Top module: `tone_divider`

## Requirements
- R1: After reset, freq_out and uflow_pulse are 0, the reload buffer holds 0, counting is halted and the tick source is the full clock.
- R2: A strobe on lo_wr writes nib_data into bits 3:0 of the reload buffer, and a strobe on hi_wr writes it into bits 7:4. Neither strobe changes the other half.
- R3: A strobe on lo_wr or hi_wr clears the run bit. When such a strobe arrives in the same cycle as a mode write with mode_run = 1, the strobe wins and counting stays halted.
- R4: On a mode write, mode_src and mode_run are captured. On the edge where the run bit goes from 0 to 1, the counter loads the reload buffer, so a restart begins a full period.
- R5: With mode_src = 0 every clock is a tick. The first uflow_pulse comes reload + 1 edges after the edge that set the run bit, and later pulses follow every reload + 1 edges.
- R6: With mode_src = 1 a tick occurs only on edges whose number since reset release is a multiple of 64. The first pulse comes on the (reload + 1)-th such tick after the run edge, and later pulses follow every 64 × (reload + 1) edges.
- R7: At a tick with the counter at 0, the counter reloads from the buffer and uflow_pulse is high for exactly that one cycle. This keeps the period constant from one underflow to the next.
- R8: freq_out changes level on the same edge that raises uflow_pulse, and on no other edge.
- R9: A reload value of 0 in full-clock mode gives an underflow on every edge, so uflow_pulse stays high and freq_out toggles every cycle.
- R10: While the run bit is clear, no underflow occurs and freq_out holds its level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_wr | input | 1 | Write strobe for the low half of the reload buffer |
| hi_wr | input | 1 | Write strobe for the high half of the reload buffer |
| nib_data | input | 4 | Data for a reload-half write |
| mode_wr | input | 1 | Mode write strobe |
| mode_src | input | 1 | Tick source: 0 = every clock, 1 = divide by 64 |
| mode_run | input | 1 | Run bit written on mode_wr |
| freq_out | output | 1 | Square-wave tone output |
| uflow_pulse | output | 1 | One-cycle underflow indication |

## Verification
The main function is driven with several reload values:
- 0 shows that an underflow happens at every tick.
- 5 gives a short, regular train.
- 0x23 is written as two halves, and 0x27 follows from rewriting only the low half. These show that each half lands in its own bits.
- 255 exercises the full counter width.

A slow-source run with reload 2 separates the prescaler phase from the reload count. Stopping partway through a period and then restarting shows whether a restart reloads the counter or resumes the old count. A halves write made together with a run-setting mode write shows which of the two wins.

// File: rtl/tone_div_pkg.sv
package tone_div_pkg;

    localparam int unsigned TD_CNT_W_DEF   = 8;
    localparam int unsigned TD_PRE_DIV_DEF = 64;

    typedef enum logic {
        SRC_FULL = 1'b0,
        SRC_DIV  = 1'b1
    } clk_src_e;

endpackage

// File: rtl/tone_ctrl_regs.sv
module tone_ctrl_regs
    import tone_div_pkg::*;
#(
    parameter int unsigned CNT_W = TD_CNT_W_DEF,
    localparam int unsigned NIB_W = CNT_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lo_wr_i,
    input  logic             hi_wr_i,
    input  logic [NIB_W-1:0] nib_i,
    input  logic             mode_wr_i,
    input  logic             mode_src_i,
    input  logic             mode_run_i,
    output logic [CNT_W-1:0] reload_o,
    output clk_src_e         src_o,
    output logic             run_o,
    output logic             arm_o
);

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        clk_src_e         src;
        logic             run;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  nib_any;

    always_comb begin
        ctl_d   = ctl_q;
        nib_any = lo_wr_i | hi_wr_i;
        if (lo_wr_i) begin
            ctl_d.reload[NIB_W-1:0] = nib_i;
        end
        if (hi_wr_i) begin
            ctl_d.reload[CNT_W-1:NIB_W] = nib_i;
        end
        if (mode_wr_i) begin
            ctl_d.src = clk_src_e'(mode_src_i);
            ctl_d.run = mode_run_i;
        end
        // a buffer write always halts counting, even against a mode write
        if (nib_any) begin
            ctl_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{reload: '0, src: SRC_FULL, run: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign reload_o = ctl_q.reload;
    assign src_o    = ctl_q.src;
    assign run_o    = ctl_q.run;
    assign arm_o    = ctl_d.run & ~ctl_q.run;

    AST_NIBBLE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr_i || hi_wr_i) |=> !run_o); // R3

    AST_MODE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_i && !lo_wr_i && !hi_wr_i) |=> (run_o == $past(mode_run_i))); // R4

    AST_HI_HALF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr_i |=> (reload_o[CNT_W-1:NIB_W] == $past(nib_i))); // R2

    AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr_i && !hi_wr_i) |=> $stable(reload_o[CNT_W-1:NIB_W])); // R2

endmodule

// File: rtl/tone_prescaler.sv
module tone_prescaler
    import tone_div_pkg::*;
#(
    parameter int unsigned PRE_DIV = TD_PRE_DIV_DEF
) (
    input  logic     clk,
    input  logic     rst_n,
    input  clk_src_e src_i,
    output logic     tick_o
);

    generate
        if (PRE_DIV > 1) begin : g_div
            localparam int unsigned PRE_W = $clog2(PRE_DIV);
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

            typedef struct packed {
                logic [PRE_W-1:0] phase;
            } pre_t;

            pre_t pre_d, pre_q;
            logic wrap;

            always_comb begin
                pre_d = pre_q;
                wrap  = (pre_q.phase == PRE_LAST);
                pre_d.phase = wrap ? '0 : pre_q.phase + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_d;
                end
            end

            assign tick_o = (src_i == SRC_FULL) ? 1'b1 : wrap;

            AST_DIV_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                (src_i == SRC_DIV && tick_o) |=> !(src_i == SRC_DIV && tick_o)); // R6
        end else begin : g_nodiv
            logic unused_in;
            assign unused_in = clk ^ rst_n ^ src_i;
            assign tick_o    = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/tone_count_core.sv
module tone_count_core
    import tone_div_pkg::*;
#(
    parameter int unsigned CNT_W = TD_CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             arm_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             fout_o,
    output logic             uflow_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fout;
        logic             uflow;
    } core_t;

    core_t cor_d, cor_q;
    logic  at_zero;

    always_comb begin
        cor_d       = cor_q;
        cor_d.uflow = 1'b0;
        at_zero     = (cor_q.cnt == '0);
        if (arm_i) begin
            cor_d.cnt = reload_i;
        end else if (run_i && tick_i) begin
            if (at_zero) begin
                cor_d.cnt   = reload_i;
                cor_d.uflow = 1'b1;
                cor_d.fout  = ~cor_q.fout;
            end else begin
                cor_d.cnt = cor_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cor_q <= '0;
        end else begin
            cor_q <= cor_d;
        end
    end

    assign fout_o  = cor_q.fout;
    assign uflow_o = cor_q.uflow;

    AST_ARM_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (cor_q.cnt == $past(reload_i))); // R4

    AST_RELOAD_ON_UFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        uflow_o |-> (cor_q.cnt == $past(reload_i))); // R7

    AST_FOUT_WITH_UFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fout_o != $past(fout_o)) |-> uflow_o); // R8

    AST_UFLOW_FLIPS_FOUT: assert property (@(posedge clk) disable iff (!rst_n)
        uflow_o |-> (fout_o != $past(fout_o))); // R8

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !arm_i && cor_q.cnt != '0) |=> (cor_q.cnt == $past(cor_q.cnt) - 1'b1)); // R5

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !arm_i) |=> ($stable(cor_q.cnt) && !uflow_o)); // R10

endmodule

// File: rtl/tone_divider.sv
module tone_divider
    import tone_div_pkg::*;
#(
    parameter int unsigned CNT_W   = TD_CNT_W_DEF,
    parameter int unsigned PRE_DIV = TD_PRE_DIV_DEF,
    localparam int unsigned NIB_W  = CNT_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lo_wr,
    input  logic             hi_wr,
    input  logic [NIB_W-1:0] nib_data,
    input  logic             mode_wr,
    input  logic             mode_src,
    input  logic             mode_run,
    output logic             freq_out,
    output logic             uflow_pulse
);

    logic [CNT_W-1:0] reload_w;
    clk_src_e         src_w;
    logic             run_w;
    logic             arm_w;
    logic             tick_w;

    tone_ctrl_regs #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .lo_wr_i    (lo_wr),
        .hi_wr_i    (hi_wr),
        .nib_i      (nib_data),
        .mode_wr_i  (mode_wr),
        .mode_src_i (mode_src),
        .mode_run_i (mode_run),
        .reload_o   (reload_w),
        .src_o      (src_w),
        .run_o      (run_w),
        .arm_o      (arm_w)
    );

    tone_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_w),
        .tick_o (tick_w)
    );

    tone_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_w),
        .arm_i    (arm_w),
        .tick_i   (tick_w),
        .reload_i (reload_w),
        .fout_o   (freq_out),
        .uflow_o  (uflow_pulse)
    );

endmodule

// File: tb/tone_divider_test.sv
module tone_divider_test;

    localparam int PRE = 64;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       lo_wr, hi_wr, mode_wr, mode_src, mode_run;
    logic [3:0] nib;
    logic       freq_out, uflow_pulse;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    logic exp_fout = 1'b0;

    typedef struct {
        int    at;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    tone_divider uut (
        .clk(clk), .rst_n(rst_n), .lo_wr(lo_wr), .hi_wr(hi_wr), .nib_data(nib),
        .mode_wr(mode_wr), .mode_src(mode_src), .mode_run(mode_run),
        .freq_out(freq_out), .uflow_pulse(uflow_pulse)
    );

    always @(posedge clk) if (rst_n === 1'b1) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // monitor: compares observed underflows with the scoreboard queue
    always @(negedge clk) begin
        exp_t e;
        if (rst_n === 1'b1) begin
            while (exp_q.size() > 0 && exp_q[0].at < cyc) begin
                check(1'b0, exp_q[0].tag, "missing underflow pulse", cyc, exp_q[0].at);
                void'(exp_q.pop_front());
            end
            if (uflow_pulse) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected underflow pulse", cyc, -1);
                end else begin
                    e = exp_q.pop_front();
                    check(e.at == cyc, e.tag, "underflow cycle", cyc, e.at);
                    exp_fout = ~exp_fout;
                    check(freq_out == exp_fout, "R8", "freq_out level at underflow", int'(freq_out), int'(exp_fout));
                end
            end
        end
    end

    task automatic put_nib(bit hi, logic [3:0] v);
        @(negedge clk);
        lo_wr = !hi; hi_wr = hi; nib = v;
        @(negedge clk);
        lo_wr = 1'b0; hi_wr = 1'b0;
    endtask

    task automatic load(int v);
        put_nib(1'b0, v[3:0]);
        put_nib(1'b1, v[7:4]);
    endtask

    task automatic set_mode(bit run, bit slow, output int edge_no);
        @(negedge clk);
        mode_wr = 1'b1; mode_run = run; mode_src = slow;
        edge_no = cyc + 1;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    // driver side: pushes the expected underflow cycles of a train
    task automatic expect_train(int e0, int n, bit slow, int k, string tag, output int last);
        int first, step;
        first = slow ? ((e0 / PRE) + 1) * PRE + PRE * n : e0 + n + 1;
        step  = slow ? PRE * (n + 1) : n + 1;
        for (int i = 0; i < k; i++) begin
            exp_t e;
            e.at = first + i * step; e.tag = tag;
            exp_q.push_back(e);
            last = e.at;
        end
    endtask

    task automatic wait_until(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic quiet(int n, string tag);
        logic f;
        f = freq_out;
        repeat (n) @(negedge clk);
        check(freq_out == f, tag, "freq_out held while halted", int'(freq_out), int'(f));
        check(exp_q.size() == 0, tag, "expectations left while halted", exp_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R5 watchdog expired: actual=%0d expected=done", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int e, s, last;
        rst_n = 1'b0; lo_wr = 0; hi_wr = 0; nib = '0; mode_wr = 0; mode_src = 0; mode_run = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(freq_out == 1'b0, "R1", "freq_out after reset", int'(freq_out), 0);
        check(uflow_pulse == 1'b0, "R1", "uflow_pulse after reset", int'(uflow_pulse), 0);

        // R1: buffer is 0 after reset, so a bare run gives an underflow every edge
        set_mode(1'b1, 1'b0, e);
        expect_train(e, 0, 1'b0, 4, "R1", last);
        wait_until(last - 2);
        set_mode(1'b0, 1'b0, s);
        quiet(20, "R10");

        // R5: reload 5, stopped by a buffer write (R3)
        load(5);
        set_mode(1'b1, 1'b0, e);
        expect_train(e, 5, 1'b0, 3, "R5", last);
        wait_until(last);
        put_nib(1'b0, 4'h5);
        quiet(40, "R3");

        // R2: both halves, value 0x23
        load(8'h23);
        set_mode(1'b1, 1'b0, e);
        expect_train(e, 8'h23, 1'b0, 2, "R2", last);
        wait_until(last);
        set_mode(1'b0, 1'b0, s);
        quiet(10, "R10");

        // R2: rewriting only the low half gives 0x27
        put_nib(1'b0, 4'h7);
        set_mode(1'b1, 1'b0, e);
        expect_train(e, 8'h27, 1'b0, 2, "R2", last);
        wait_until(last);
        set_mode(1'b0, 1'b0, s);
        quiet(10, "R10");

        // R7: full width, period repeats through reload
        load(255);
        set_mode(1'b1, 1'b0, e);
        expect_train(e, 255, 1'b0, 2, "R7", last);
        wait_until(last);
        set_mode(1'b0, 1'b0, s);
        quiet(10, "R10");

        // R6: divided tick source
        load(2);
        set_mode(1'b1, 1'b1, e);
        expect_train(e, 2, 1'b1, 3, "R6", last);
        wait_until(last);
        set_mode(1'b0, 1'b1, s);
        quiet(200, "R10");

        // R4: stop partway through, restart begins a full period
        load(10);
        set_mode(1'b1, 1'b0, e);
        wait_until(e + 4);
        set_mode(1'b0, 1'b0, s);
        quiet(30, "R4");
        set_mode(1'b1, 1'b0, e);
        expect_train(e, 10, 1'b0, 1, "R4", last);
        wait_until(last);
        set_mode(1'b0, 1'b0, s);
        quiet(10, "R10");

        // R3: buffer write and run-setting mode write in the same cycle
        @(negedge clk);
        lo_wr = 1'b1; nib = 4'h0; mode_wr = 1'b1; mode_run = 1'b1; mode_src = 1'b0;
        @(negedge clk);
        lo_wr = 1'b0; mode_wr = 1'b0;
        quiet(300, "R3");

        // R9: reload 0, continuous underflow
        load(0);
        set_mode(1'b1, 1'b0, e);
        expect_train(e, 0, 1'b0, 6, "R9", last);
        wait_until(last - 2);
        set_mode(1'b0, 1'b0, s);
        quiet(20, "R9");

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R5", "pending expectations at end", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule